// File: doc/BRIEF.md
# Store Issue Arbiter with Oldest-Operation Fallback

This block sits beside a load queue and a store queue. Each cycle it decides whether the store at the store-queue issue pointer may be sent to memory. It judges the store's readiness and checks it against every load entry, using an order matrix (which store is older than which load) and an address-match matrix. The address comparison may be approximate, so a reported conflict can be false. To guarantee forward progress in that case, the block can also force out the oldest pending operation. This is either a fallback load, offered as a one-hot load-queue entry, or a fallback store, which overrides a reported conflict. A forced operation goes out only when no operation of the other kind is still in flight.

An optional pipeline stage registers the store-side verdict. It also registers the load allocation flags, the load address flags and the load-queue head. To hide the extra cycle, the stage evaluates both the current store entry and the following one, and keeps whichever will sit at the issue pointer after the clock edge. Fallback issue is meant for queues that do not forward store data to loads and that have a single load memory channel.

Top module: `store_fallback_arb`

## Requirements
- R1: A store request counts as valid only when its entry at the issue pointer is allocated and both its address flag and its data flag are set. A store whose data flag is clear is never enabled.
- R2: The store conflicts with load entry i when all four of these hold: the load is allocated, its data flag is clear, bit `i*STQ_DEPTH+j` of `st_older_mtx` is 0 for store j, and either bit `i*STQ_DEPTH+j` of `addr_match_mtx` is 1 or the load's address flag is clear.
- R3: `st_en` is 1 exactly when the store is valid and either no load conflicts or the fallback store is permitted. `st_idx` always equals `st_issue_ptr`.
- R4: The fallback load candidate is the first load entry that is allocated and not issued, searched cyclically upward from the position of the one-hot `ld_head_oh` and wrapping past the top entry. An issued load is never offered.
- R5: The candidate counts as oldest overall only when the store at the issue pointer is not older than it.
- R6: `fb_ld_oh` carries the oldest-overall candidate when that candidate's address flag is set and `st_issue_ptr` equals `st_resp_ptr`; otherwise it is all zero. `fb_ld_en` is the OR of its bits, and at most one bit is ever set.
- R7: The fallback store is permitted when no candidate is oldest overall and no load is outstanding. A load is outstanding when it is issued and its data flag is clear.
- R8: With `PIPE_EN=1`, the store verdict, the load allocation flags, the load address flags and the head are registered. If `st_issue_adv` is 1 at the edge, the registered verdict is for entry `st_issue_ptr+1` (modulo depth); otherwise it is for `st_issue_ptr`. Load issued flags, load data flags and both pointers act in the same cycle.
- R9: While reset is high the registered stage clears, so `st_en` and `fb_ld_en` are 0 in the cycle that follows a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_alloc | input | LDQ_DEPTH | Load entry allocated |
| ld_issued | input | LDQ_DEPTH | Load entry sent to memory |
| ld_addr_ok | input | LDQ_DEPTH | Load address known |
| ld_data_ok | input | LDQ_DEPTH | Load data returned |
| st_alloc | input | STQ_DEPTH | Store entry allocated |
| st_addr_ok | input | STQ_DEPTH | Store address known |
| st_data_ok | input | STQ_DEPTH | Store data known |
| ld_head_oh | input | LDQ_DEPTH | One-hot oldest load-queue position |
| st_issue_ptr | input | clog2(STQ_DEPTH) | Store issue pointer |
| st_resp_ptr | input | clog2(STQ_DEPTH) | Store response pointer |
| st_issue_adv | input | 1 | Issue pointer advances at this edge |
| st_older_mtx | input | LDQ_DEPTH*STQ_DEPTH | Bit i*STQ_DEPTH+j: store j older than load i |
| addr_match_mtx | input | LDQ_DEPTH*STQ_DEPTH | Bit i*STQ_DEPTH+j: addresses of load i and store j match |
| st_en | output | 1 | Issue the store at the pointer |
| st_idx | output | clog2(STQ_DEPTH) | Index of the store to issue |
| fb_ld_oh | output | LDQ_DEPTH | One-hot fallback load entry |
| fb_ld_en | output | 1 | Issue the fallback load |

## Verification
The checks take for granted that `ld_head_oh` is one-hot and that the pointers stay below the store depth. They also assume `st_issue_adv` is raised only in a cycle whose pointer is followed by `st_issue_ptr+1` in the next cycle. The bench always drives a single-bit head and pointers in range. Its random sweep, however, lets the pointer jump freely between cycles. For that reason the bench's model records, at every edge, which entry the pipeline stage should have latched, and it never assumes that the pointer moves in sequence.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    typedef enum logic {
        PICK_CURR = 1'b0,
        PICK_NEXT = 1'b1
    } look_sel_e;

    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/sfa_entry_eval.sv
module sfa_entry_eval #(
    parameter int LDQ_DEPTH = 8,
    parameter int STQ_DEPTH = 8,
    localparam int PTR_W = $clog2(STQ_DEPTH),
    localparam int MTX_W = LDQ_DEPTH * STQ_DEPTH
) (
    input  logic [PTR_W-1:0]     idx,
    input  logic [STQ_DEPTH-1:0] st_alloc,
    input  logic [STQ_DEPTH-1:0] st_addr_ok,
    input  logic [STQ_DEPTH-1:0] st_data_ok,
    input  logic [LDQ_DEPTH-1:0] ld_alloc,
    input  logic [LDQ_DEPTH-1:0] ld_done,
    input  logic [LDQ_DEPTH-1:0] ld_addr_ok,
    input  logic [MTX_W-1:0]     older_mtx,
    input  logic [MTX_W-1:0]     match_mtx,
    output logic                 req_valid,
    output logic [LDQ_DEPTH-1:0] conf_vec,
    output logic [LDQ_DEPTH-1:0] older_vec
);

    always_comb begin
        req_valid = st_alloc[idx] & st_addr_ok[idx] & st_data_ok[idx];
        for (int i = 0; i < LDQ_DEPTH; i++) begin
            older_vec[i] = older_mtx[i*STQ_DEPTH + int'(idx)];
            conf_vec[i]  = ld_alloc[i] & ~ld_done[i] & ~older_vec[i]
                         & (match_mtx[i*STQ_DEPTH + int'(idx)] | ~ld_addr_ok[i]);
        end
    end

endmodule

// File: rtl/sfa_issue_stage.sv
module sfa_issue_stage
    import sfa_pkg::*;
#(
    parameter int LDQ_DEPTH = 8,
    parameter bit PIPE_EN   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic                 cur_valid,
    input  logic [LDQ_DEPTH-1:0] cur_conf,
    input  logic [LDQ_DEPTH-1:0] cur_older,
    input  logic                 nxt_valid,
    input  logic [LDQ_DEPTH-1:0] nxt_conf,
    input  logic [LDQ_DEPTH-1:0] nxt_older,
    input  logic [LDQ_DEPTH-1:0] ld_alloc,
    input  logic [LDQ_DEPTH-1:0] ld_addr_ok,
    input  logic [LDQ_DEPTH-1:0] ld_head_oh,
    output logic                 v_q,
    output logic [LDQ_DEPTH-1:0] conf_q,
    output logic [LDQ_DEPTH-1:0] older_q,
    output logic [LDQ_DEPTH-1:0] alloc_q,
    output logic [LDQ_DEPTH-1:0] addr_q,
    output logic [LDQ_DEPTH-1:0] head_q
);

    generate
        if (PIPE_EN) begin : g_reg
            look_sel_e sel;
            assign sel = adv ? PICK_NEXT : PICK_CURR;

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q     <= 1'b0;
                    conf_q  <= '0;
                    older_q <= '0;
                    alloc_q <= '0;
                    addr_q  <= '0;
                    head_q  <= '0;
                end else begin
                    alloc_q <= ld_alloc;
                    addr_q  <= ld_addr_ok;
                    head_q  <= ld_head_oh;
                    case (sel)
                        PICK_NEXT: begin
                            v_q     <= nxt_valid;
                            conf_q  <= nxt_conf;
                            older_q <= nxt_older;
                        end
                        default: begin
                            v_q     <= cur_valid;
                            conf_q  <= cur_conf;
                            older_q <= cur_older;
                        end
                    endcase
                end
            end
        end else begin : g_comb
            assign v_q     = cur_valid;
            assign conf_q  = cur_conf;
            assign older_q = cur_older;
            assign alloc_q = ld_alloc;
            assign addr_q  = ld_addr_ok;
            assign head_q  = ld_head_oh;
        end
    endgenerate

endmodule

// File: rtl/sfa_ld_pick.sv
module sfa_ld_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] head_oh,
    output logic [N-1:0] grant
);

    always_comb begin
        int  h;
        int  pos;
        logic found;
        h     = 0;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (head_oh[i]) h = i;
        end
        for (int k = 0; k < N; k++) begin
            pos = (h + k) % N;
            if (!found && req[pos]) begin
                grant[pos] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/store_fallback_arb.sv
module store_fallback_arb
    import sfa_pkg::*;
#(
    parameter int LDQ_DEPTH   = 8,
    parameter int STQ_DEPTH   = 8,
    parameter bit PIPE_EN     = 1'b1,
    parameter bit FB_LOAD_EN  = 1'b1,
    parameter bit FB_STORE_EN = 1'b1,
    localparam int PTR_W = $clog2(STQ_DEPTH),
    localparam int MTX_W = LDQ_DEPTH * STQ_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LDQ_DEPTH-1:0] ld_alloc,
    input  logic [LDQ_DEPTH-1:0] ld_issued,
    input  logic [LDQ_DEPTH-1:0] ld_addr_ok,
    input  logic [LDQ_DEPTH-1:0] ld_data_ok,
    input  logic [STQ_DEPTH-1:0] st_alloc,
    input  logic [STQ_DEPTH-1:0] st_addr_ok,
    input  logic [STQ_DEPTH-1:0] st_data_ok,
    input  logic [LDQ_DEPTH-1:0] ld_head_oh,
    input  logic [PTR_W-1:0]     st_issue_ptr,
    input  logic [PTR_W-1:0]     st_resp_ptr,
    input  logic                 st_issue_adv,
    input  logic [MTX_W-1:0]     st_older_mtx,
    input  logic [MTX_W-1:0]     addr_match_mtx,
    output logic                 st_en,
    output logic [PTR_W-1:0]     st_idx,
    output logic [LDQ_DEPTH-1:0] fb_ld_oh,
    output logic                 fb_ld_en
);

    logic [PTR_W-1:0]     nxt_ptr;
    logic                 cur_valid, nxt_valid, v_q;
    logic [LDQ_DEPTH-1:0] cur_conf, nxt_conf, conf_q;
    logic [LDQ_DEPTH-1:0] cur_older, nxt_older, older_q;
    logic [LDQ_DEPTH-1:0] alloc_q, addr_q, head_q;
    logic [LDQ_DEPTH-1:0] cand_oh, ld_oldest_oh;
    logic                 st_outstanding, ld_outstanding, fb_st_ok;

    assign nxt_ptr = PTR_W'(ring_next(int'(st_issue_ptr), STQ_DEPTH));

    sfa_entry_eval #(.LDQ_DEPTH(LDQ_DEPTH), .STQ_DEPTH(STQ_DEPTH)) u_cur (
        .idx(st_issue_ptr), .st_alloc(st_alloc), .st_addr_ok(st_addr_ok),
        .st_data_ok(st_data_ok), .ld_alloc(ld_alloc), .ld_done(ld_data_ok),
        .ld_addr_ok(ld_addr_ok), .older_mtx(st_older_mtx), .match_mtx(addr_match_mtx),
        .req_valid(cur_valid), .conf_vec(cur_conf), .older_vec(cur_older)
    );

    sfa_entry_eval #(.LDQ_DEPTH(LDQ_DEPTH), .STQ_DEPTH(STQ_DEPTH)) u_nxt (
        .idx(nxt_ptr), .st_alloc(st_alloc), .st_addr_ok(st_addr_ok),
        .st_data_ok(st_data_ok), .ld_alloc(ld_alloc), .ld_done(ld_data_ok),
        .ld_addr_ok(ld_addr_ok), .older_mtx(st_older_mtx), .match_mtx(addr_match_mtx),
        .req_valid(nxt_valid), .conf_vec(nxt_conf), .older_vec(nxt_older)
    );

    sfa_issue_stage #(.LDQ_DEPTH(LDQ_DEPTH), .PIPE_EN(PIPE_EN)) u_stage (
        .clk(clk), .rst(rst), .adv(st_issue_adv),
        .cur_valid(cur_valid), .cur_conf(cur_conf), .cur_older(cur_older),
        .nxt_valid(nxt_valid), .nxt_conf(nxt_conf), .nxt_older(nxt_older),
        .ld_alloc(ld_alloc), .ld_addr_ok(ld_addr_ok), .ld_head_oh(ld_head_oh),
        .v_q(v_q), .conf_q(conf_q), .older_q(older_q),
        .alloc_q(alloc_q), .addr_q(addr_q), .head_q(head_q)
    );

    sfa_ld_pick #(.N(LDQ_DEPTH)) u_pick (
        .req(alloc_q & ~ld_issued), .head_oh(head_q), .grant(cand_oh)
    );

    assign ld_oldest_oh   = cand_oh & ~older_q;
    assign st_outstanding = (st_issue_ptr != st_resp_ptr);
    assign ld_outstanding = |(ld_issued & ~ld_data_ok);

    generate
        if (FB_LOAD_EN) begin : g_fbld
            assign fb_ld_oh = st_outstanding ? '0 : (ld_oldest_oh & addr_q);
        end else begin : g_nofbld
            assign fb_ld_oh = '0;
        end
        if (FB_STORE_EN) begin : g_fbst
            assign fb_st_ok = ~(|ld_oldest_oh) & ~ld_outstanding;
        end else begin : g_nofbst
            assign fb_st_ok = 1'b0;
        end
    endgenerate

    assign fb_ld_en = |fb_ld_oh;
    assign st_en    = v_q & (~(|conf_q) | fb_st_ok);
    assign st_idx   = st_issue_ptr;

endmodule

// File: rtl/sfa_chk.sv
module sfa_chk #(
    parameter int LDQ_DEPTH = 8,
    parameter int STQ_DEPTH = 8,
    parameter bit PIPE_EN   = 1'b1,
    localparam int PTR_W = $clog2(STQ_DEPTH)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [LDQ_DEPTH-1:0] ld_issued,
    input logic [LDQ_DEPTH-1:0] ld_addr_ok,
    input logic [PTR_W-1:0]     st_issue_ptr,
    input logic [PTR_W-1:0]     st_resp_ptr,
    input logic                 st_en,
    input logic [LDQ_DEPTH-1:0] fb_ld_oh,
    input logic                 fb_ld_en
);

    // R6
    fbld_store_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fb_ld_en |-> (st_issue_ptr == st_resp_ptr));

    // R6
    fbld_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fb_ld_oh));

    // R4
    fbld_unissued_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_ld_oh & ld_issued) == '0);

    generate
        if (PIPE_EN) begin : g_pipe_chk
            // R8
            fbld_addr_known_chk: assert property (@(posedge clk) disable iff (rst)
                fb_ld_en |-> ((fb_ld_oh & $past(ld_addr_ok)) != '0));

            // R9
            reset_quiet_chk: assert property (@(posedge clk)
                $past(rst) |-> (!st_en && !fb_ld_en));
        end
    endgenerate

endmodule

bind store_fallback_arb sfa_chk #(
    .LDQ_DEPTH(LDQ_DEPTH), .STQ_DEPTH(STQ_DEPTH), .PIPE_EN(PIPE_EN)
) u_chk (.*);

// File: tb/store_fallback_arb_tb.sv
module store_fallback_arb_tb;
    localparam int L = 8;
    localparam int S = 8;
    localparam int PW = $clog2(S);
    localparam int MW = L * S;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [L-1:0] ld_alloc = '0, ld_issued = '0, ld_addr_ok = '0, ld_data_ok = '0, ld_head_oh = 1;
    logic [S-1:0] st_alloc = '0, st_addr_ok = '0, st_data_ok = '0;
    logic [PW-1:0] st_issue_ptr = '0, st_resp_ptr = '0;
    logic st_issue_adv = 1'b0;
    logic [MW-1:0] st_older_mtx = '0, addr_match_mtx = '0;
    logic st_en, fb_ld_en;
    logic [PW-1:0] st_idx;
    logic [L-1:0] fb_ld_oh;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model of the registered stage
    logic m_valid;
    logic [L-1:0] m_conf, m_older, m_alloc, m_addr, m_head;

    always #10 clk = ~clk;

    store_fallback_arb u_dut (
        .clk(clk), .rst(rst), .ld_alloc(ld_alloc), .ld_issued(ld_issued),
        .ld_addr_ok(ld_addr_ok), .ld_data_ok(ld_data_ok), .st_alloc(st_alloc),
        .st_addr_ok(st_addr_ok), .st_data_ok(st_data_ok), .ld_head_oh(ld_head_oh),
        .st_issue_ptr(st_issue_ptr), .st_resp_ptr(st_resp_ptr), .st_issue_adv(st_issue_adv),
        .st_older_mtx(st_older_mtx), .addr_match_mtx(addr_match_mtx),
        .st_en(st_en), .st_idx(st_idx), .fb_ld_oh(fb_ld_oh), .fb_ld_en(fb_ld_en)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 1'b0; m_conf = '0; m_older = '0;
            m_alloc = '0; m_addr = '0; m_head = '0;
        end else begin
            int k;
            k = st_issue_adv ? (int'(st_issue_ptr) + 1) % S : int'(st_issue_ptr);
            m_valid = st_alloc[k] && st_addr_ok[k] && st_data_ok[k];
            for (int i = 0; i < L; i++) begin
                m_older[i] = st_older_mtx[i*S+k];
                m_conf[i]  = ld_alloc[i] && !ld_data_ok[i] && !m_older[i]
                          && (addr_match_mtx[i*S+k] || !ld_addr_ok[i]);
            end
            m_alloc = ld_alloc; m_addr = ld_addr_ok; m_head = ld_head_oh;
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check(input string tag);
        logic [L-1:0] req, cand, oldest, e_oh;
        int h;
        bit found, ld_out, fbst, e_st;
        req = m_alloc & ~ld_issued;
        h = 0;
        for (int i = 0; i < L; i++) if (m_head[i]) h = i;
        cand = '0; found = 0;
        for (int k = 0; k < L; k++) begin
            if (!found && req[(h+k)%L]) begin cand[(h+k)%L] = 1'b1; found = 1; end
        end
        oldest = cand & ~m_older;
        e_oh = (st_issue_ptr != st_resp_ptr) ? '0 : (oldest & m_addr);
        ld_out = |(ld_issued & ~ld_data_ok);
        fbst = (oldest == '0) && !ld_out;
        e_st = m_valid && ((m_conf == '0) || fbst);
        cmp(tag, "st_en", int'(st_en), int'(e_st));
        cmp("R3", "st_idx", int'(st_idx), int'(st_issue_ptr));
        cmp(tag, "fb_ld_oh", int'(fb_ld_oh), int'(e_oh));
        cmp(tag, "fb_ld_en", int'(fb_ld_en), int'(e_oh != '0));
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic quiet();
        ld_alloc = '0; ld_issued = '0; ld_addr_ok = '0; ld_data_ok = '0;
        st_alloc = '0; st_addr_ok = '0; st_data_ok = '0; ld_head_oh = 1;
        st_issue_ptr = '0; st_resp_ptr = '0; st_issue_adv = 0;
        st_older_mtx = '0; addr_match_mtx = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset with fully ready inputs
        st_alloc = '1; st_addr_ok = '1; st_data_ok = '1;
        ld_alloc = '1; ld_addr_ok = '1;
        step("R9");
        step("R9");
        quiet();
        rst = 1'b0;
        step("R9");

        // R1: store lacks data, then gains it
        st_alloc[0] = 1; st_addr_ok[0] = 1;
        step("R1");
        cmp("R1", "st_en no data", int'(st_en), 0);
        st_data_ok[0] = 1;
        step("R1");
        cmp("R1", "st_en ready", int'(st_en), 1);

        // R2: younger store vs pending load 3 with matching address
        ld_alloc[3] = 1; addr_match_mtx[3*S+0] = 1;
        step("R2");
        cmp("R2", "st_en conflict", int'(st_en), 0);
        st_older_mtx[3*S+0] = 1;
        step("R2");
        cmp("R2", "st_en store older", int'(st_en), 1);

        // R5 / R6: load 3 oldest with known address
        st_older_mtx[3*S+0] = 0; ld_addr_ok[3] = 1;
        step("R5");
        cmp("R6", "fb_ld_oh", int'(fb_ld_oh), 8);
        st_resp_ptr = 3'd5;
        step("R6");
        cmp("R6", "fb_ld_en store pending", int'(fb_ld_en), 0);
        st_resp_ptr = '0;

        // R7: false conflict overridden when no load is oldest
        quiet();
        st_alloc[0] = 1; st_addr_ok[0] = 1; st_data_ok[0] = 1;
        ld_alloc[0] = 1; st_older_mtx[0*S+0] = 1;
        ld_alloc[5] = 1; addr_match_mtx[5*S+0] = 1; ld_addr_ok[5] = 1;
        step("R7");
        cmp("R7", "st_en override", int'(st_en), 1);
        ld_alloc[2] = 1; ld_issued[2] = 1; st_older_mtx[2*S+0] = 1;
        step("R7");
        cmp("R7", "st_en load outstanding", int'(st_en), 0);

        // R4: cyclic search from head 6 wraps to entry 1
        quiet();
        ld_alloc[1] = 1; ld_alloc[5] = 1; ld_addr_ok = '1; ld_head_oh = 8'b0100_0000;
        step("R4");
        cmp("R4", "fb_ld_oh wrap", int'(fb_ld_oh), 2);
        ld_head_oh = 8'b0000_1000;
        step("R4");
        cmp("R4", "fb_ld_oh head3", int'(fb_ld_oh), 32);
        ld_issued[5] = 1; ld_data_ok[5] = 1;
        step("R4");
        cmp("R4", "fb_ld_oh skip issued", int'(fb_ld_oh), 2);

        // R8: look-ahead picks next entry on advance
        quiet();
        st_issue_ptr = 3'd2; st_resp_ptr = 3'd2;
        st_alloc[3] = 1; st_addr_ok[3] = 1; st_data_ok[3] = 1; st_issue_adv = 1;
        step("R8");
        cmp("R8", "st_en lookahead", int'(st_en), 1);
        st_issue_ptr = 3'd3; st_resp_ptr = 3'd3; st_issue_adv = 0;
        step("R8");
        cmp("R8", "st_en held", int'(st_en), 1);
        st_issue_adv = 1;
        step("R8");
        cmp("R8", "st_en next empty", int'(st_en), 0);

        // R3: random sweep
        for (int n = 0; n < 4000; n++) begin
            ld_alloc   = (n % 2) ? L'($urandom & $urandom & $urandom) : L'($urandom);
            ld_issued  = (n % 3 == 0) ? '0 : L'($urandom & $urandom);
            ld_addr_ok = L'($urandom | $urandom);
            ld_data_ok = L'($urandom);
            st_alloc   = S'($urandom | $urandom);
            st_addr_ok = S'($urandom | $urandom);
            st_data_ok = S'($urandom | $urandom);
            ld_head_oh = L'(1) << ($urandom % L);
            st_issue_ptr = PW'($urandom % S);
            st_resp_ptr  = ($urandom % 3 == 0) ? PW'($urandom % S) : st_issue_ptr;
            st_issue_adv = 1'($urandom % 2);
            st_older_mtx   = MW'({$urandom, $urandom});
            addr_match_mtx = MW'({$urandom & $urandom, $urandom & $urandom});
            step("R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule